// File: doc/BRIEF.md
# Parallel Port Reverse Receiver (Nibble and Byte)

This block is the host end of a parallel port running in one of the two reverse directions, where the peripheral sends data to the host. It runs a four-phase interlock with the peripheral. The host shows it is ready by pulling its ready/busy line low. The peripheral then puts data on the lines and pulls its acknowledge line low. The host answers by raising ready/busy, and the peripheral ends the phase by releasing acknowledge.

Two capture modes are provided. In nibble mode each phase carries four bits on the status lines, and two phases build one byte. In byte mode each phase carries a full byte on the data bus, and the host closes each byte with one low pulse on its strobe line. All peripheral inputs are asynchronous, so they pass through a two-flop synchronizer before use. Data is taken on the synchronized falling edge of acknowledge.

Finished bytes leave the block on a valid/ready interface. The host does not signal ready again while a byte is still waiting to be accepted, so the peripheral is held back and no byte is lost. Mode negotiation, the peripheral side, transceivers and direction control are outside the block. Pins carry their active-low line levels as they appear on the cable.

Top module: `pp_rev_rx`

## Requirements
- R1: After reset, `autofd_n_o` is 0 (host ready), `strobe_n_o` is 1 and `byte_valid_o` is 0.
- R2: After the synchronized falling edge of `ack_n_i` is seen while the host is ready, `autofd_n_o` goes to 1 (busy) and stays at 1 for as long as `ack_n_i` stays low.
- R3: In nibble mode (`mode_byte_i` = 0), the first nibble taken from `status_i` fills bits 3:0 of the output byte and the second fills bits 7:4. `byte_valid_o` stays 0 after the first nibble and rises only after the second.
- R4: In byte mode (`mode_byte_i` = 1), each acknowledge phase delivers the 8-bit value on `data_i` to `byte_o`, unchanged.
- R5: In byte mode, after `ack_n_i` returns high, `strobe_n_o` goes low exactly once for exactly `STB_CYC` clock cycles, and only while `autofd_n_o` is 1. In nibble mode `strobe_n_o` never goes low.
- R6: While `byte_valid_o` is 1 and `byte_ready_i` is 0, `autofd_n_o` stays 1 and `byte_o` holds its value.
- R7: A byte is accepted in the cycle where `byte_valid_o` and `byte_ready_i` are both 1. `byte_valid_o` is 0 in the next cycle.
- R8: The value delivered is the one present when acknowledge fell. Changes on `status_i` or `data_i` after the host has gone busy have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_byte_i | input | 1 | 0 = nibble capture from status lines, 1 = byte capture from data bus |
| ack_n_i | input | 1 | Peripheral acknowledge, active low, asynchronous |
| status_i | input | 4 | Peripheral status lines carrying a nibble |
| data_i | input | 8 | Peripheral data bus |
| autofd_n_o | output | 1 | Host ready (0) / busy (1) |
| strobe_n_o | output | 1 | Host strobe, active low, pulsed once per byte in byte mode |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | `byte_o` holds a byte not yet accepted |
| byte_ready_i | input | 1 | Consumer accepts the byte |

## Verification
If the handshake state is wrong, the cable shows it at once. The peripheral is stuck waiting on a ready/busy level that never arrives, so the bench's peripheral model stalls within a few cycles. A wrong nibble position or a lost half-byte shows as a swapped or missing byte at the scoreboard at the next accepted transfer. A broken strobe timer shows as a pulse of the wrong width or count within one byte period. A lost backpressure hold shows as the host going ready again while a byte is pending.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

  typedef enum logic [2:0] {
    LK_READY  = 3'd0,
    LK_BUSY   = 3'd1,
    LK_STROBE = 3'd2,
    LK_GATE   = 3'd3
  } link_st_t;

  // Joins the second (upper) and first (lower) nibble into one byte.
  function automatic logic [7:0] join_nibbles(input logic [3:0] upper,
                                              input logic [3:0] lower);
    return {upper, lower};
  endfunction

endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q[s] <= RST_VAL;
        end else if (s == 0) begin
          chain_q[s] <= d_i;
        end else begin
          chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/pp_link_fsm.sv
module pp_link_fsm
  import pp_rx_pkg::*;
#(
  parameter int STB_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_s,
  input  logic mode_byte,
  input  logic out_valid,
  output logic cap_evt,
  output logic autofd_n_o,
  output logic strobe_n_o
);

  localparam int CW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
  localparam logic [CW-1:0] STB_LAST = CW'(STB_CYC - 1);

  link_st_t    st_q, st_d;
  logic [CW-1:0] stb_cnt_q;
  logic        ack_prev_q;
  logic        ack_fall;
  logic        ack_released;
  logic        byte_phase_q;
  logic        stb_done;

  assign ack_fall     = ack_prev_q & ~ack_n_s;
  assign ack_released = ack_n_s;
  assign cap_evt      = (st_q == LK_READY) && ack_fall;
  assign stb_done     = (stb_cnt_q == STB_LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LK_READY:  if (cap_evt) st_d = LK_BUSY;
      LK_BUSY:   if (ack_released) st_d = byte_phase_q ? LK_STROBE : LK_GATE;
      LK_STROBE: if (stb_done) st_d = LK_GATE;
      LK_GATE:   if (!out_valid) st_d = LK_READY;
      default:   st_d = LK_GATE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= LK_READY;
      stb_cnt_q    <= '0;
      ack_prev_q   <= 1'b1;
      byte_phase_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ack_prev_q <= ack_n_s;
      if (cap_evt) byte_phase_q <= mode_byte;
      if (st_q == LK_STROBE) stb_cnt_q <= stb_cnt_q + 1'b1;
      else                   stb_cnt_q <= '0;
    end
  end

  assign autofd_n_o = (st_q != LK_READY);
  assign strobe_n_o = (st_q != LK_STROBE);

  // R2
  busy_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> autofd_n_o);

  // R2
  busy_while_ack_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (autofd_n_o && !ack_n_s) |=> autofd_n_o);

  // R5
  strobe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n_o |-> autofd_n_o);

endmodule

// File: rtl/pp_nib_pack.sv
module pp_nib_pack
  import pp_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_evt,
  input  logic       mode_byte,
  input  logic [3:0] nib_s,
  input  logic [7:0] dat_s,
  input  logic       ready_i,
  output logic [7:0] byte_o,
  output logic       valid_o,
  output logic       byte_done
);

  logic       upper_next_q;
  logic [3:0] low_nib_q;
  logic [7:0] out_q;
  logic       valid_q;
  logic       accept;

  assign byte_done = cap_evt && (mode_byte || upper_next_q);
  assign accept    = valid_q && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_next_q <= 1'b0;
      low_nib_q    <= '0;
      out_q        <= '0;
      valid_q      <= 1'b0;
    end else begin
      if (cap_evt && !mode_byte) begin
        if (!upper_next_q) low_nib_q <= nib_s;
        upper_next_q <= ~upper_next_q;
      end else if (cap_evt) begin
        upper_next_q <= 1'b0;
      end
      if (byte_done) begin
        out_q   <= mode_byte ? dat_s : join_nibbles(nib_s, low_nib_q);
        valid_q <= 1'b1;
      end else if (accept) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign byte_o  = out_q;
  assign valid_o = valid_q;

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !valid_q);

  // R7
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !valid_q);

endmodule

// File: rtl/pp_rev_rx.sv
module pp_rev_rx
  import pp_rx_pkg::*;
#(
  parameter int STB_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_byte_i,
  input  logic       ack_n_i,
  input  logic [3:0] status_i,
  input  logic [7:0] data_i,
  output logic       autofd_n_o,
  output logic       strobe_n_o,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  input  logic       byte_ready_i
);

  localparam int SYNC_W = 1 + 4 + 8;

  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              ack_n_s;
  logic [3:0]        nib_s;
  logic [7:0]        dat_s;
  logic              cap_evt;
  logic              byte_done;

  assign raw_bus = {ack_n_i, status_i, data_i};
  assign {ack_n_s, nib_s, dat_s} = sync_bus;

  pp_sync #(.W(SYNC_W), .STAGES(2), .RST_VAL({1'b1, 12'h000})) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_bus),
    .q_o   (sync_bus)
  );

  pp_link_fsm #(.STB_CYC(STB_CYC)) u_link (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_n_s    (ack_n_s),
    .mode_byte  (mode_byte_i),
    .out_valid  (byte_valid_o),
    .cap_evt    (cap_evt),
    .autofd_n_o (autofd_n_o),
    .strobe_n_o (strobe_n_o)
  );

  pp_nib_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_evt   (cap_evt),
    .mode_byte (mode_byte_i),
    .nib_s     (nib_s),
    .dat_s     (dat_s),
    .ready_i   (byte_ready_i),
    .byte_o    (byte_o),
    .valid_o   (byte_valid_o),
    .byte_done (byte_done)
  );

  // R6
  hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> (autofd_n_o && byte_valid_o && $stable(byte_o)));

endmodule

// File: tb/pp_rev_rx_tb_top.sv
module pp_rev_rx_tb_top;

  localparam int STB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_byte_i = 1'b0;
  logic       ack_n_i = 1'b1;
  logic [3:0] status_i = '0;
  logic [7:0] data_i = '0;
  logic       autofd_n_o, strobe_n_o, byte_valid_o;
  logic [7:0] byte_o;
  logic       rdy = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int pulses = 0;
  int run = 0;
  logic [7:0] exp_q [$];

  always #4 clk = ~clk;

  pp_rev_rx #(.STB_CYC(STB)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_byte_i  (mode_byte_i),
    .ack_n_i      (ack_n_i),
    .status_i     (status_i),
    .data_i       (data_i),
    .autofd_n_o   (autofd_n_o),
    .strobe_n_o   (strobe_n_o),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .byte_ready_i (rdy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // strobe pulse monitor: R5 width
  always @(negedge clk) begin
    if (rst_n && !strobe_n_o) begin
      run++;
    end else if (run != 0) begin
      pulses++;
      check(run == STB, "R5 strobe width", run, STB);
      run = 0;
    end
  end

  // scoreboard monitor: R3 R4 R7
  always @(negedge clk) begin
    if (rst_n && byte_valid_o && rdy) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected byte", byte_o, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(byte_o == e, "R3/R4 byte value", byte_o, e);
      end
    end
  end

  task automatic wait_fd(input logic lvl);
    while (autofd_n_o !== lvl) @(negedge clk);
  endtask

  // one acknowledge phase as the peripheral
  task automatic put_unit(input logic [7:0] v, input bit nib);
    bit held;
    wait_fd(1'b0);
    if (nib) status_i = v[3:0];
    else     data_i   = v;
    repeat (2) @(negedge clk);
    ack_n_i = 1'b0;
    wait_fd(1'b1);
    status_i = ~status_i;   // R8 scramble after busy
    data_i   = ~data_i;
    held = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (autofd_n_o !== 1'b1) held = 1'b0;
    end
    check(held, "R2 busy while ack low", autofd_n_o, 1);
    ack_n_i = 1'b1;
  endtask

  task automatic send(input logic [7:0] v);
    int p0;
    p0 = pulses;
    exp_q.push_back(v);
    if (mode_byte_i) begin
      put_unit(v, 1'b0);
      repeat (STB + 12) @(negedge clk);
      check(pulses == p0 + 1, "R5 one strobe per byte", pulses - p0, 1);
    end else begin
      put_unit({4'h0, v[3:0]}, 1'b1);
      repeat (8) @(negedge clk);
      check(byte_valid_o == 1'b0, "R3 no byte after first nibble", byte_valid_o, 0);
      put_unit({4'h0, v[7:4]}, 1'b1);
      repeat (STB + 12) @(negedge clk);
      check(pulses == p0, "R5 no strobe in nibble mode", pulses - p0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(autofd_n_o == 1'b0, "R1 ready after reset", autofd_n_o, 0);
    check(strobe_n_o == 1'b1, "R1 strobe idle", strobe_n_o, 1);
    check(byte_valid_o == 1'b0, "R1 no valid", byte_valid_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // nibble mode, R3 R8
    mode_byte_i = 1'b0;
    send(8'hA5);
    send(8'h3C);
    send(8'hF0);
    send(8'h0F);

    // byte mode, R4 R5 R8
    mode_byte_i = 1'b1;
    send(8'h00);
    send(8'hFF);
    send(8'h96);

    // backpressure, R6 then R7
    rdy = 1'b0;
    send(8'h5A);
    begin
      bit hold_ok;
      hold_ok = 1'b1;
      repeat (30) begin
        @(negedge clk);
        if (!(autofd_n_o && byte_valid_o && byte_o == 8'h5A)) hold_ok = 1'b0;
      end
      check(hold_ok, "R6 busy and hold while pending", byte_o, 8'h5A);
    end
    rdy = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(byte_valid_o == 1'b0, "R7 valid drops after accept", byte_valid_o, 0);

    // back to nibble mode under backpressure
    mode_byte_i = 1'b0;
    wait_fd(1'b0);
    rdy = 1'b0;
    send(8'hC3);
    repeat (20) @(negedge clk);
    check(autofd_n_o == 1'b1, "R6 no ready while pending (nibble)", autofd_n_o, 1);
    rdy = 1'b1;
    send(8'h81);

    begin
      int guard;
      guard = 0;
      while (exp_q.size() != 0 && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    check(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule